// File: doc/BRIEF.md
# Single-Clock FIFO with Overflow Error Flag

This block is a first-in first-out buffer for one clock domain. A producer offers a word with a write request, a consumer takes the oldest word with a read request, and both may act in the same cycle. The storage is a power-of-two array addressed by a write pointer and a read pointer that wrap at the address width. One slot is always left unused, so the buffer holds at most `DEPTH-1` words.

The buffer keeps two registered look-ahead flags. One says the next lone write would overflow, and the other says the next read would find nothing. Both are computed from the next fill level, so each request is judged without an adder in the decision path. A request that cannot be honoured leaves the pointers and the fill count as they were. A write into a full buffer that has no matching read is an overflow, and it sets an error flag that stays high until reset. A read of an empty buffer is not reported.

Top module: `ovf_sync_fifo`

## Requirements
- R1: A cycle with `rst` high at the clock edge empties the buffer. After that edge `fill` is 0, `not_empty` is 0 and `err` is 0.
- R2: While `not_empty` is high, `rd_data` shows the oldest stored word. Words leave in the order they were accepted, and `rd_data` holds its value across cycles without a read.
- R3: After each edge, `fill` equals the number of words accepted minus the number of words taken since the last reset.
- R4: `not_empty` is high exactly when `fill` is nonzero.
- R5: The buffer is full when `fill` equals `DEPTH-1`. This is the largest value `fill` can reach.
- R6: A write request without a read request while full is an overflow. The word is dropped, `fill` stays the same and `err` is high after that edge.
- R7: Once `err` is high it stays high until reset, whatever the later traffic.
- R8: A read request while empty is ignored. The read does not move the read pointer, `fill` does not drop, and `err` does not change.
- R9: A write request to an empty buffer is accepted even when a read request arrives in the same cycle. After the edge `fill` is 1 and `rd_data` is the new word.
- R10: A write and a read in the same cycle while full both happen. `fill` stays at `DEPTH-1`, no error is raised and the order is kept.
- R11: The pointers wrap at the address width, and order and count stay correct over many passes through the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | Request to store `wr_data` |
| wr_data | input | DATA_W | Word offered for storage |
| rd_req | input | 1 | Request to remove the oldest word |
| rd_data | output | DATA_W | Oldest stored word |
| not_empty | output | 1 | High while at least one word is stored |
| fill | output | $clog2(DEPTH) | Number of stored words, registered |
| err | output | 1 | Overflow seen since reset |

## Verification
A look-ahead flag that disagrees with the pointers shows at the ports on the next edge. If the empty flag is wrong, a read is either refused while `not_empty` is high, or it pulls a stale word, and `fill` wraps to `DEPTH-1`. If the full flag is wrong, a lone write into a full buffer either raises no error or overwrites the oldest word, and the bad word appears on `rd_data` within `DEPTH-1` reads. A pointer that moves on a refused request makes `fill` and the word order drift apart from that edge on. So the bench compares count, flags and head word after every single edge against an arithmetic model.

// File: rtl/ovf_fifo_pkg.sv
package ovf_fifo_pkg;

   // Decision taken for one cycle of requests
   typedef struct packed {
      logic wr_acc;   // write is performed
      logic rd_acc;   // read is performed
      logic ovf;      // write refused because the buffer is full
   } fifo_grant_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ovf_fifo_grant.sv
module ovf_fifo_grant
   import ovf_fifo_pkg::*;
(
   input  logic        wr_req,
   input  logic        rd_req,
   input  logic        next_wr_ovf,
   input  logic        next_rd_unf,
   output fifo_grant_t grant
);

   always_comb begin
      // A read from an empty buffer fails regardless of a concurrent write
      grant.rd_acc = rd_req && !next_rd_unf;
      // A write while full only succeeds if a read frees a slot
      grant.wr_acc = wr_req && (!next_wr_ovf || grant.rd_acc);
      grant.ovf    = wr_req && next_wr_ovf && !grant.rd_acc;
   end

endmodule

// File: rtl/ovf_fifo_track.sv
module ovf_fifo_track
   import ovf_fifo_pkg::*;
#(
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  fifo_grant_t   grant,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic [AW-1:0] fill,
   output logic          next_wr_ovf,
   output logic          next_rd_unf,
   output logic          err
);

   localparam logic [AW-1:0] FULL_LVL = AW'(DEPTH - 1);

   logic [AW-1:0] wr_ptr_q = '0;
   logic [AW-1:0] rd_ptr_q = '0;
   logic [AW-1:0] fill_q   = '0;
   logic          ovf_q    = 1'b0;
   logic          unf_q    = 1'b1;
   logic          err_q    = 1'b0;
   logic [AW-1:0] fill_nxt;

   always_comb begin
      fill_nxt = fill_q + AW'(grant.wr_acc) - AW'(grant.rd_acc);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         fill_q   <= '0;
         ovf_q    <= 1'b0;
         unf_q    <= 1'b1;
         err_q    <= 1'b0;
      end else begin
         if (grant.wr_acc) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (grant.rd_acc) rd_ptr_q <= rd_ptr_q + 1'b1;
         fill_q <= fill_nxt;
         ovf_q  <= (fill_nxt == FULL_LVL);
         unf_q  <= (fill_nxt == '0);
         if (grant.ovf) err_q <= 1'b1;
      end
   end

   assign wr_ptr      = wr_ptr_q;
   assign rd_ptr      = rd_ptr_q;
   assign fill        = fill_q;
   assign next_wr_ovf = ovf_q;
   assign next_rd_unf = unf_q;
   assign err         = err_q;

endmodule

// File: rtl/ovf_fifo_store.sv
module ovf_fifo_store #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DEPTH       = 16,
   parameter bit          CLEAR_STORE = 1'b0,
   localparam int unsigned AW         = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [DATA_W-1:0] q = '0;
      logic              hit;
      assign hit = wr_en && (wr_addr == AW'(i));
      if (CLEAR_STORE) begin : g_clr
         always_ff @(posedge clk) begin
            if (rst)      q <= '0;
            else if (hit) q <= wr_data;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit) q <= wr_data;
         end
      end
      assign words[i] = q;
   end

   assign rd_data = words[rd_addr];

endmodule

// File: rtl/ovf_sync_fifo.sv
module ovf_sync_fifo
   import ovf_fifo_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DEPTH       = 16,
   parameter bit          CLEAR_STORE = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_req,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     rd_req,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     not_empty,
   output logic [$clog2(DEPTH)-1:0] fill,
   output logic                     err
);

   localparam int unsigned AW = $clog2(DEPTH);

   if (!is_pow2(DEPTH)) begin : g_bad_depth
      $error("ovf_sync_fifo: DEPTH must be a power of two and at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("ovf_sync_fifo: DATA_W must be at least 1");
   end

   fifo_grant_t   grant;
   logic          next_wr_ovf;
   logic          next_rd_unf;
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] rd_ptr;

   ovf_fifo_grant u_grant (
      .wr_req      (wr_req),
      .rd_req      (rd_req),
      .next_wr_ovf (next_wr_ovf),
      .next_rd_unf (next_rd_unf),
      .grant       (grant)
   );

   ovf_fifo_track #(.DEPTH(DEPTH)) u_track (
      .clk         (clk),
      .rst         (rst),
      .grant       (grant),
      .wr_ptr      (wr_ptr),
      .rd_ptr      (rd_ptr),
      .fill        (fill),
      .next_wr_ovf (next_wr_ovf),
      .next_rd_unf (next_rd_unf),
      .err         (err)
   );

   ovf_fifo_store #(
      .DATA_W      (DATA_W),
      .DEPTH       (DEPTH),
      .CLEAR_STORE (CLEAR_STORE)
   ) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (grant.wr_acc),
      .wr_addr (wr_ptr),
      .wr_data (wr_data),
      .rd_addr (rd_ptr),
      .rd_data (rd_data)
   );

   assign not_empty = !next_rd_unf;

endmodule

// File: rtl/ovf_sync_fifo_chk.sv
module ovf_sync_fifo_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_req,
   input logic              rd_req,
   input logic [DATA_W-1:0] rd_data,
   input logic              not_empty,
   input logic [AW-1:0]     fill,
   input logic              err
);

   localparam logic [AW-1:0] FULL_LVL = AW'(DEPTH - 1);

   // High when the previous edge was a live, non-reset cycle
   logic prev_live = 1'b0;
   logic rst_seen  = 1'b0;
   always_ff @(posedge clk) begin
      prev_live <= !rst && rst_seen;
      if (rst) rst_seen <= 1'b1;
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      (rst_seen && $past(rst)) |-> (fill == '0 && !not_empty && !err));

   assert_head_stable_R2: assert property (@(posedge clk) disable iff (rst)
      (prev_live && $past(not_empty && !rd_req)) |-> $stable(rd_data));

   assert_fill_up_R3: assert property (@(posedge clk) disable iff (rst)
      (prev_live && $past(wr_req && !rd_req && fill != FULL_LVL))
      |-> (fill == $past(fill) + 1'b1));

   assert_flag_match_R4: assert property (@(posedge clk) disable iff (rst)
      rst_seen |-> (not_empty == (fill != '0)));

   assert_overflow_R6: assert property (@(posedge clk) disable iff (rst)
      (prev_live && $past(wr_req && !rd_req && fill == FULL_LVL))
      |-> (err && fill == FULL_LVL));

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      (prev_live && $past(err)) |-> err);

   assert_underflow_R8: assert property (@(posedge clk) disable iff (rst)
      (prev_live && $past(rd_req && !wr_req && fill == '0))
      |-> (fill == '0 && err == $past(err)));

   assert_write_empty_R9: assert property (@(posedge clk) disable iff (rst)
      (prev_live && $past(wr_req && fill == '0)) |-> (fill == AW'(1)));

   assert_full_pass_R10: assert property (@(posedge clk) disable iff (rst)
      (prev_live && $past(wr_req && rd_req && fill == FULL_LVL))
      |-> (fill == FULL_LVL && err == $past(err)));

endmodule

bind ovf_sync_fifo ovf_sync_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .wr_req    (wr_req),
   .rd_req    (rd_req),
   .rd_data   (rd_data),
   .not_empty (not_empty),
   .fill      (fill),
   .err       (err)
);

// File: tb/ovf_sync_fifo_tb.sv
module ovf_sync_fifo_tb;

   localparam int unsigned DW  = 8;
   localparam int unsigned DEP = 4;
   localparam int unsigned AW  = $clog2(DEP);
   localparam int          CAP = DEP - 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_req = 1'b0;
   logic          rd_req = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          not_empty;
   logic [AW-1:0] fill;
   logic          err;

   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   logic [DW-1:0] mdl[$];
   logic          err_exp = 1'b0;
   string         data_tag = "R2";

   always #10 clk = ~clk;   // 50 MHz

   ovf_sync_fifo #(.DATA_W(DW), .DEPTH(DEP)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .wr_req    (wr_req),
      .wr_data   (wr_data),
      .rd_req    (rd_req),
      .rd_data   (rd_data),
      .not_empty (not_empty),
      .fill      (fill),
      .err       (err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R3 fill count", int'(fill), mdl.size());
      chk("R4 not_empty", int'(not_empty), int'(mdl.size() != 0));
      chk(err_exp ? "R7 err held" : "R6 err level", int'(err), int'(err_exp));
      if (mdl.size() != 0) chk({data_tag, " head word"}, int'(rd_data), int'(mdl[0]));
   endtask

   // Called at a falling edge; returns at the next falling edge after checking
   task automatic step(input logic w, input logic r, input logic [DW-1:0] d);
      bit rd_ok, wr_ok;
      wr_req  = w;
      rd_req  = r;
      wr_data = d;
      rd_ok = r && (mdl.size() != 0);
      wr_ok = w && ((mdl.size() < CAP) || rd_ok);
      @(posedge clk);
      if (w && !wr_ok) err_exp = 1'b1;
      if (rd_ok) void'(mdl.pop_front());
      if (wr_ok) mdl.push_back(d);
      @(negedge clk);
      compare_all();
   endtask

   task automatic do_reset();
      rst = 1'b1;
      wr_req = 1'b0;
      rd_req = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      mdl.delete();
      err_exp = 1'b0;
      chk("R1 fill after reset", int'(fill), 0);
      chk("R1 not_empty after reset", int'(not_empty), 0);
      chk("R1 err after reset", int'(err), 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] lfsr;
      @(negedge clk);
      do_reset();

      // R8: read while empty, alone, is ignored
      step(1'b0, 1'b1, 8'h00);
      chk("R8 fill after empty read", int'(fill), 0);
      chk("R8 err after empty read", int'(err), 0);

      // R9: write and read together into empty
      step(1'b1, 1'b1, 8'hA1);
      chk("R9 fill after write+read on empty", int'(fill), 1);
      chk("R9 head after write+read on empty", int'(rd_data), 8'hA1);

      // R5: fill to capacity
      step(1'b1, 1'b0, 8'hA2);
      step(1'b1, 1'b0, 8'hA3);
      chk("R5 full level", int'(fill), CAP);

      // R10: simultaneous read and write when full
      step(1'b1, 1'b1, 8'hA4);
      chk("R10 fill stays full", int'(fill), CAP);
      chk("R10 no error", int'(err), 0);
      chk("R10 head advanced", int'(rd_data), 8'hA2);

      // R6: lone write when full
      step(1'b1, 1'b0, 8'hEE);
      chk("R6 fill unchanged", int'(fill), CAP);
      chk("R6 err raised", int'(err), 1);
      chk("R6 head kept", int'(rd_data), 8'hA2);

      // R7: err held through drain and more traffic; R2 order
      step(1'b0, 1'b1, 8'h00);
      chk("R2 order second", int'(rd_data), 8'hA3);
      step(1'b0, 1'b1, 8'h00);
      chk("R2 order third", int'(rd_data), 8'hA4);
      step(1'b0, 1'b1, 8'h00);
      step(1'b0, 1'b1, 8'h00);
      step(1'b1, 1'b0, 8'h11);
      chk("R7 err still high", int'(err), 1);

      do_reset();

      // Exhaustive: every fill level x every request pair
      for (int lvl = 0; lvl <= CAP; lvl++) begin
         for (int c = 0; c < 4; c++) begin
            do_reset();
            for (int k = 0; k < lvl; k++) step(1'b1, 1'b0, DW'(8'h30 + k));
            step(c[1], c[0], DW'(8'h80 + 4 * lvl + c));
            if (lvl == 0 && c == 1) chk("R8 sweep empty read", int'(fill), 0);
            if (lvl == 0 && c == 3) chk("R9 sweep write+read empty", int'(fill), 1);
            if (lvl == CAP && c == 2) chk("R6 sweep overflow err", int'(err), 1);
            if (lvl == CAP && c == 3) chk("R10 sweep full pass", int'(err), 0);
         end
      end

      // Long pseudo-random run exercising pointer wrap
      do_reset();
      data_tag = "R11";
      lfsr = 16'hACE1;
      for (int n = 0; n < 3000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0] | lfsr[3], lfsr[1] | lfsr[5], lfsr[15:8]);
         if (err_exp && (n % 97 == 0)) begin
            do_reset();
         end
      end
      chk("R11 count consistent after run", int'(fill), mdl.size());

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule